// File: doc/BRIEF.md
# Two-Way Write-Through Data Cache with Posted Store Queue

This block is a data cache controller placed between a processor's load/store port and a slower memory. Each set holds two ways, each with a valid bit, a tag and a full data block. On every request, both tags of the addressed set are compared with the request tag in the same cycle. A hit is the OR of the two match signals. The match signals then steer a multiplexer that returns the requested word from the matching way.

Stores always go to memory through a four-entry posted FIFO. A store that hits also updates the word in the cached line. A store that misses leaves the cache untouched: no block is fetched. The processor is held back only when the FIFO has no free entry.

A load miss first waits for the FIFO to empty, so memory is never read ahead of an older buffered store. It then reads the whole block over a separate block-read channel. The block is installed in the least-recently-used way of the set, and the requested word is returned.

Top module: `wt2way_cache`

## Requirements
- R1: The byte address splits into tag, set index and block offset. With the default geometry these are bits 31:10, 9:5 and 4:0, and bits 4:2 pick the 32-bit word within the block. Addresses that share index bits compete for the same two ways.
- R2: A load that hits is accepted with `cpu_req_ready` high, and `cpu_rsp_valid` rises in the next cycle with the word from the matching way. No block read is issued.
- R3: A load that misses does not assert `mem_rd_req` while any store is still queued. It then fetches the block and returns the requested word of that block. The word reflects every store accepted before the load.
- R4: Each set keeps one LRU bit. It points away from the way last touched by a hit or a fill, and a load miss replaces the way it points at.
- R5: A store hit writes its word into the cached line and also queues the same write for memory.
- R6: A store miss queues the write for memory only. It fetches no block and allocates nothing, so a later load of that address still misses.
- R7: The store queue holds 4 entries. Stores are accepted while it has a free entry. When it is full, stores see `cpu_req_ready` low but loads are still accepted.
- R8: Queued writes leave one at a time in acceptance order. Each holds `mem_wr_addr` and `mem_wr_data` steady until `mem_wr_ack`.
- R9: After reset all lines are invalid and the queue is empty. `cpu_req_ready` is 1, and `cpu_rsp_valid`, `mem_rd_req` and `mem_wr_req` are 0. The first load of any set misses.
- R10: `mem_rd_addr` is the block-aligned address of the missing load, with its offset bits zero, and it is held until `mem_rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle when both are high |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Byte address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | Load data valid, one-cycle pulse |
| cpu_rsp_rdata | output | DATA_W | Load data |
| mem_rd_req | output | 1 | Block read request |
| mem_rd_addr | output | ADDR_W | Block-aligned read address |
| mem_rd_valid | input | 1 | Block read data present |
| mem_rd_data | input | BLOCK_BYTES*8 | Whole block, word 0 in the low bits |
| mem_wr_req | output | 1 | Word write request from queue head |
| mem_wr_addr | output | ADDR_W | Write byte address |
| mem_wr_data | output | DATA_W | Write data |
| mem_wr_ack | input | 1 | Head write accepted by memory |

## Verification
A load hit answers exactly one cycle after acceptance, so the bench samples `cpu_rsp_valid` at the first falling edge after the accepting rising edge and nowhere else. Miss responses depend on how long the queue takes to drain and how fast the memory answers. For those, the bench waits falling edge by falling edge for the response pulse, within a bound. It then checks both the returned word and how many block reads its memory model served, which tells a hit from a miss at the ports. Queue effects are observed after a drain wait, once `mem_wr_req` has fallen: the bench compares the ordered log of acknowledged writes with the stores it issued. The full-queue stall is sampled at the falling edge before the clock edge that would otherwise accept the store.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
   typedef enum logic [1:0] {
      CS_IDLE  = 2'd0,
      CS_DRAIN = 2'd1,
      CS_FETCH = 2'd2
   } cstate_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
   parameter int DEPTH = 4,
   parameter int WIDTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (!wtc_pkg::is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("wtc_wbuf: DEPTH must be a power of two, at least 2");
   end

   logic [WIDTH-1:0] slot [DEPTH];
   logic [PTR_W-1:0] rd_ptr, wr_ptr;
   logic [PTR_W:0]   count;
   logic             do_push, do_pop;

   assign full    = (count == (PTR_W+1)'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = slot[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) slot[wr_ptr] <= din;
   end
endmodule

// File: rtl/wtc_way.sv
module wtc_way #(
   parameter int SETS   = 32,
   parameter int TAG_W  = 22,
   parameter int BLK_W  = 256,
   parameter int DATA_W = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [$clog2(SETS)-1:0]         rd_set,
   output logic                            o_valid,
   output logic [TAG_W-1:0]                o_tag,
   output logic [BLK_W-1:0]                o_blk,
   input  logic                            fill_en,
   input  logic [$clog2(SETS)-1:0]         fill_set,
   input  logic [TAG_W-1:0]                fill_tag,
   input  logic [BLK_W-1:0]                fill_blk,
   input  logic                            word_en,
   input  logic [$clog2(SETS)-1:0]         word_set,
   input  logic [$clog2(BLK_W/DATA_W)-1:0] word_sel,
   input  logic [DATA_W-1:0]               word_data
);
   logic [SETS-1:0]  vld;
   logic [TAG_W-1:0] tags [SETS];
   logic [BLK_W-1:0] blks [SETS];

   assign o_valid = vld[rd_set];
   assign o_tag   = tags[rd_set];
   assign o_blk   = blks[rd_set];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       vld <= '0;
      else if (fill_en) vld[fill_set] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tags[fill_set] <= fill_tag;
         blks[fill_set] <= fill_blk;
      end else if (word_en) begin
         blks[word_set][word_sel*DATA_W +: DATA_W] <= word_data;
      end
   end
endmodule

// File: rtl/wt2way_cache.sv
module wt2way_cache #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int BLOCK_BYTES = 32,
   parameter int SETS        = 32,
   parameter int WB_DEPTH    = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cpu_req_valid,
   output logic                     cpu_req_ready,
   input  logic                     cpu_req_we,
   input  logic [ADDR_W-1:0]        cpu_req_addr,
   input  logic [DATA_W-1:0]        cpu_req_wdata,
   output logic                     cpu_rsp_valid,
   output logic [DATA_W-1:0]        cpu_rsp_rdata,
   output logic                     mem_rd_req,
   output logic [ADDR_W-1:0]        mem_rd_addr,
   input  logic                     mem_rd_valid,
   input  logic [BLOCK_BYTES*8-1:0] mem_rd_data,
   output logic                     mem_wr_req,
   output logic [ADDR_W-1:0]        mem_wr_addr,
   output logic [DATA_W-1:0]        mem_wr_data,
   input  logic                     mem_wr_ack
);
   import wtc_pkg::*;

   localparam int WAYS   = 2;
   localparam int BLK_W  = BLOCK_BYTES * 8;
   localparam int OFF_W  = $clog2(BLOCK_BYTES);
   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
   localparam int WORDS  = BLK_W / DATA_W;
   localparam int WSEL_W = $clog2(WORDS);
   localparam int BSEL_W = OFF_W - WSEL_W;

   if (!is_pow2(SETS) || !is_pow2(BLOCK_BYTES) || !is_pow2(DATA_W / 8)) begin : g_bad_geom
      $error("wt2way_cache: SETS, BLOCK_BYTES and word bytes must be powers of two");
   end
   if (WORDS < 2 || TAG_W < 1 || DATA_W % 8 != 0) begin : g_bad_split
      $error("wt2way_cache: block must hold two or more words and leave a tag");
   end

   // request fields
   logic [TAG_W-1:0]  req_tag;
   logic [IDX_W-1:0]  req_set;
   logic [WSEL_W-1:0] req_word;
   assign req_tag  = cpu_req_addr[ADDR_W-1 -: TAG_W];
   assign req_set  = cpu_req_addr[OFF_W +: IDX_W];
   assign req_word = cpu_req_addr[BSEL_W +: WSEL_W];

   cstate_e           state;
   logic [TAG_W-1:0]  miss_tag;
   logic [IDX_W-1:0]  miss_set;
   logic [WSEL_W-1:0] miss_word;
   logic [SETS-1:0]   lru;

   logic              wb_full, wb_empty, wb_push, wb_pop;
   logic [ADDR_W+DATA_W-1:0] wb_head;

   logic [WAYS-1:0]   way_vld, hit_way, fill_way, word_way;
   logic [TAG_W-1:0]  way_tag [WAYS];
   logic [BLK_W-1:0]  way_blk [WAYS];
   logic              lookup_hit, accept, ld_accept, st_accept, fetch_done, victim;
   logic [DATA_W-1:0] hit_word;

   assign cpu_req_ready = (state == CS_IDLE) && !(cpu_req_we && wb_full);
   assign accept        = cpu_req_valid && cpu_req_ready;
   assign ld_accept     = accept && !cpu_req_we;
   assign st_accept     = accept && cpu_req_we;
   assign fetch_done    = (state == CS_FETCH) && mem_rd_valid;
   assign victim        = lru[miss_set];

   // ways, parallel tag compare
   for (genvar g = 0; g < WAYS; g++) begin : g_way
      assign hit_way[g]  = way_vld[g] && (way_tag[g] == req_tag);
      assign fill_way[g] = fetch_done && (victim == 1'(g));
      assign word_way[g] = st_accept && hit_way[g];

      wtc_way #(.SETS(SETS), .TAG_W(TAG_W), .BLK_W(BLK_W), .DATA_W(DATA_W)) u_way (
         .clk       (clk),
         .rst_n     (rst_n),
         .rd_set    (req_set),
         .o_valid   (way_vld[g]),
         .o_tag     (way_tag[g]),
         .o_blk     (way_blk[g]),
         .fill_en   (fill_way[g]),
         .fill_set  (miss_set),
         .fill_tag  (miss_tag),
         .fill_blk  (mem_rd_data),
         .word_en   (word_way[g]),
         .word_set  (req_set),
         .word_sel  (req_word),
         .word_data (cpu_req_wdata)
      );
   end

   assign lookup_hit = |hit_way;

   // match-steered word mux
   always_comb begin
      hit_word = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_way[w]) hit_word = hit_word | way_blk[w][req_word*DATA_W +: DATA_W];
      end
   end

   // posted store queue
   assign wb_push = st_accept;
   assign wb_pop  = mem_wr_req && mem_wr_ack;

   wtc_wbuf #(.DEPTH(WB_DEPTH), .WIDTH(ADDR_W + DATA_W)) u_wbuf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wb_push),
      .din   ({cpu_req_addr, cpu_req_wdata}),
      .pop   (wb_pop),
      .dout  (wb_head),
      .full  (wb_full),
      .empty (wb_empty)
   );

   assign mem_wr_req  = !wb_empty;
   assign mem_wr_addr = wb_head[DATA_W +: ADDR_W];
   assign mem_wr_data = wb_head[DATA_W-1:0];

   assign mem_rd_req  = (state == CS_FETCH);
   assign mem_rd_addr = {miss_tag, miss_set, {OFF_W{1'b0}}};

   // control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= CS_IDLE;
         lru           <= '0;
         miss_tag      <= '0;
         miss_set      <= '0;
         miss_word     <= '0;
         cpu_rsp_valid <= 1'b0;
         cpu_rsp_rdata <= '0;
      end else begin
         cpu_rsp_valid <= 1'b0;
         case (state)
            CS_IDLE: begin
               if (accept && lookup_hit) lru[req_set] <= ~hit_way[1];
               if (ld_accept && lookup_hit) begin
                  cpu_rsp_valid <= 1'b1;
                  cpu_rsp_rdata <= hit_word;
               end else if (ld_accept) begin
                  miss_tag  <= req_tag;
                  miss_set  <= req_set;
                  miss_word <= req_word;
                  state     <= CS_DRAIN;
               end
            end
            CS_DRAIN: if (wb_empty) state <= CS_FETCH;
            CS_FETCH: begin
               if (mem_rd_valid) begin
                  lru[miss_set] <= ~victim;
                  cpu_rsp_valid <= 1'b1;
                  cpu_rsp_rdata <= mem_rd_data[miss_word*DATA_W +: DATA_W];
                  state         <= CS_IDLE;
               end
            end
            default: state <= CS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/wtc_cache_chk.sv
module wtc_cache_chk #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int BLOCK_BYTES = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req_valid,
   input logic              cpu_req_ready,
   input logic              cpu_req_we,
   input logic              cpu_rsp_valid,
   input logic              lookup_hit,
   input logic              wb_full,
   input logic              mem_rd_req,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              mem_rd_valid,
   input logic              mem_wr_req,
   input logic [ADDR_W-1:0] mem_wr_addr,
   input logic [DATA_W-1:0] mem_wr_data,
   input logic              mem_wr_ack
);
   localparam int OFF_W = $clog2(BLOCK_BYTES);

   // R2: load hit answers in the next cycle
   a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req_valid && cpu_req_ready && !cpu_req_we && lookup_hit |=> cpu_rsp_valid);

   // R3: no block read while stores are queued
   a_r3_drain_first: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !mem_wr_req);

   // R7: no store accepted into a full queue
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      wb_full && !(mem_wr_req && mem_wr_ack) |-> !(cpu_req_valid && cpu_req_ready && cpu_req_we));

   // R8: head write held until acknowledged
   a_r8_wr_held: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req && !mem_wr_ack |=> mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data));

   // R10: block read address aligned and held
   a_r10_rd_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> (mem_rd_addr[OFF_W-1:0] == '0));

   a_r10_rd_held: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_rd_addr));
endmodule

bind wt2way_cache wtc_cache_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLOCK_BYTES(BLOCK_BYTES)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_req_valid (cpu_req_valid),
   .cpu_req_ready (cpu_req_ready),
   .cpu_req_we    (cpu_req_we),
   .cpu_rsp_valid (cpu_rsp_valid),
   .lookup_hit    (lookup_hit),
   .wb_full       (wb_full),
   .mem_rd_req    (mem_rd_req),
   .mem_rd_addr   (mem_rd_addr),
   .mem_rd_valid  (mem_rd_valid),
   .mem_wr_req    (mem_wr_req),
   .mem_wr_addr   (mem_wr_addr),
   .mem_wr_data   (mem_wr_data),
   .mem_wr_ack    (mem_wr_ack)
);

// File: tb/wt2way_cache_test.sv
`timescale 1ns/1ps
module wt2way_cache_test;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int BB = 32;
   localparam int BW = BB * 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req_valid = 1'b0;
   logic          cpu_req_ready;
   logic          cpu_req_we = 1'b0;
   logic [AW-1:0] cpu_req_addr = '0;
   logic [DW-1:0] cpu_req_wdata = '0;
   logic          cpu_rsp_valid;
   logic [DW-1:0] cpu_rsp_rdata;
   logic          mem_rd_req;
   logic [AW-1:0] mem_rd_addr;
   logic          mem_rd_valid = 1'b0;
   logic [BW-1:0] mem_rd_data = '0;
   logic          mem_wr_req;
   logic [AW-1:0] mem_wr_addr;
   logic [DW-1:0] mem_wr_data;
   logic          mem_wr_ack = 1'b0;

   int total = 0;
   int bad = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   bit wr_hold = 1'b0;
   bit done = 1'b0;
   logic [AW-1:0] last_rd_addr = '0;
   logic [AW-1:0] wr_addr_log [64];
   logic [DW-1:0] wr_data_log [64];
   logic [DW-1:0] mem_words [logic [AW-1:0]];

   always #2 clk = ~clk;

   wt2way_cache uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
      .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
      .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
      .cpu_rsp_rdata(cpu_rsp_rdata), .mem_rd_req(mem_rd_req),
      .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
      .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req),
      .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .mem_wr_ack(mem_wr_ack)
   );

   function automatic logic [DW-1:0] model_word(input logic [AW-1:0] a);
      if (mem_words.exists(a)) return mem_words[a];
      return {a[15:0] ^ 16'h5A5A, a[15:0]};
   endfunction

   // memory model, driven on the falling edge
   always @(negedge clk) begin
      if (mem_rd_req && !mem_rd_valid) begin
         logic [BW-1:0] blk;
         for (int i = 0; i < BW / DW; i++) blk[i*DW +: DW] = model_word(mem_rd_addr + AW'(4 * i));
         mem_rd_data  <= blk;
         mem_rd_valid <= 1'b1;
         last_rd_addr <= mem_rd_addr;
         rd_cnt       <= rd_cnt + 1;
      end else begin
         mem_rd_valid <= 1'b0;
      end
      if (mem_wr_req && !mem_wr_ack && !wr_hold) begin
         mem_wr_ack             <= 1'b1;
         mem_words[mem_wr_addr] = mem_wr_data;
         wr_addr_log[wr_cnt]    <= mem_wr_addr;
         wr_data_log[wr_cnt]    <= mem_wr_data;
         wr_cnt                 <= wr_cnt + 1;
      end else begin
         mem_wr_ack <= 1'b0;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wait_ready();
      for (int n = 0; n < 200 && !cpu_req_ready; n++) @(negedge clk);
   endtask

   // issue a load; exp_hit demands the one-cycle answer and no fetch
   task automatic do_load(input logic [AW-1:0] a, input bit exp_hit, input string req);
      int r0;
      logic [DW-1:0] exp;
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_we = 1'b0; cpu_req_addr = a;
      wait_ready();
      r0 = rd_cnt;
      @(posedge clk);
      @(negedge clk);
      cpu_req_valid = 1'b0;
      if (exp_hit) begin
         check(cpu_rsp_valid === 1'b1, req, "hit answer one cycle after accept", 32'(cpu_rsp_valid), 32'd1);
      end else begin
         for (int n = 0; n < 100 && cpu_rsp_valid !== 1'b1; n++) @(negedge clk);
      end
      exp = model_word({a[AW-1:2], 2'b00});
      check(cpu_rsp_rdata === exp, req, "load data", cpu_rsp_rdata, exp);
      check(rd_cnt - r0 == (exp_hit ? 0 : 1), req, "block reads for load", 32'(rd_cnt - r0), exp_hit ? 32'd0 : 32'd1);
   endtask

   task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_we = 1'b1; cpu_req_addr = a; cpu_req_wdata = d;
      wait_ready();
      @(posedge clk);
      @(negedge clk);
      cpu_req_valid = 1'b0; cpu_req_we = 1'b0;
   endtask

   task automatic wait_drain();
      for (int n = 0; n < 200 && (mem_wr_req || mem_wr_ack); n++) @(negedge clk);
   endtask

   localparam logic [AW-1:0] A = 32'h0004_0060;  // set 3
   localparam logic [AW-1:0] B = 32'h0008_0060;  // set 3
   localparam logic [AW-1:0] C = 32'h000C_0060;  // set 3
   localparam logic [AW-1:0] D = 32'h0000_5000;  // set 0
   localparam logic [AW-1:0] E = 32'h0000_60E0;  // set 7

   task automatic t_reset();
      @(negedge clk);
      check(cpu_req_ready === 1'b1, "R9", "ready after reset", 32'(cpu_req_ready), 1);
      check(cpu_rsp_valid === 1'b0, "R9", "rsp_valid after reset", 32'(cpu_rsp_valid), 0);
      check(mem_rd_req === 1'b0 && mem_wr_req === 1'b0, "R9", "memory requests after reset",
            {30'd0, mem_rd_req, mem_wr_req}, 0);
   endtask

   task automatic t_miss_then_hit();
      do_load(A + 32'hC, 1'b0, "R9");  // compulsory miss, word 3 (R1)
      check(last_rd_addr === A, "R10", "aligned block read address", last_rd_addr, A);
      do_load(A + 32'h4, 1'b1, "R2");
      do_load(A + 32'h1C, 1'b1, "R1");
   endtask

   task automatic t_lru();
      do_load(B, 1'b0, "R4");  // fills other way
      do_load(A, 1'b1, "R4");  // A touched last
      do_load(C, 1'b0, "R4");  // must evict B
      do_load(A, 1'b1, "R4");
      do_load(B, 1'b0, "R4");
   endtask

   task automatic t_store_hit();
      int w0;
      w0 = wr_cnt;
      do_store(A + 32'h8, 32'hDEAD_0001);
      wait_drain();
      check(wr_cnt - w0 == 1, "R5", "writes posted by store hit", 32'(wr_cnt - w0), 1);
      check(wr_addr_log[w0] === A + 32'h8, "R5", "write address", wr_addr_log[w0], A + 32'h8);
      check(wr_data_log[w0] === 32'hDEAD_0001, "R5", "write data", wr_data_log[w0], 32'hDEAD_0001);
      do_load(A + 32'h8, 1'b1, "R5");
   endtask

   task automatic t_store_miss();
      int r0;
      r0 = rd_cnt;
      do_store(D + 32'h4, 32'hBEEF_0002);
      check(rd_cnt == r0, "R6", "no fetch on store miss", 32'(rd_cnt - r0), 0);
      do_load(D + 32'h4, 1'b0, "R6");  // still misses; data from drained store (R3)
      do_load(D + 32'h4, 1'b1, "R3");
   endtask

   task automatic t_full();
      int w0;
      w0 = wr_cnt;
      wr_hold = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(cpu_req_ready === 1'b1, "R7", "store slot free", 32'(cpu_req_ready), 1);
         do_store(E + 32'(4 * i), 32'hC0DE_0000 + 32'(i));
      end
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_we = 1'b1; cpu_req_addr = E + 32'h10; cpu_req_wdata = 32'h1;
      #0;
      check(cpu_req_ready === 1'b0, "R7", "store stalled when queue full", 32'(cpu_req_ready), 0);
      @(negedge clk);
      check(cpu_req_ready === 1'b0, "R7", "stall persists", 32'(cpu_req_ready), 0);
      cpu_req_we = 1'b0; cpu_req_addr = A;
      #0;
      check(cpu_req_ready === 1'b1, "R7", "load accepted while queue full", 32'(cpu_req_ready), 1);
      cpu_req_valid = 1'b0;
      do_load(A, 1'b1, "R7");
      wr_hold = 1'b0;
      wait_drain();
      check(wr_cnt - w0 == 4, "R8", "queued writes drained", 32'(wr_cnt - w0), 4);
      for (int i = 0; i < 4; i++) begin
         check(wr_addr_log[w0 + i] === E + 32'(4 * i), "R8", "write order address",
               wr_addr_log[w0 + i], E + 32'(4 * i));
         check(wr_data_log[w0 + i] === 32'hC0DE_0000 + 32'(i), "R8", "write order data",
               wr_data_log[w0 + i], 32'hC0DE_0000 + 32'(i));
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_miss_then_hit();
      t_lru();
      t_store_hit();
      t_store_miss();
      t_full();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule